// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block sits behind the write side of a parallel NOR flash bus. Each cycle with the write strobe high presents an address and a data word. The decoder matches those writes against a fixed grammar of keyed unlock cycles. When a grammar ends in a legal command, it raises a single-cycle start pulse for the embedded-operation engine that sits beside it. The engine is outside this block.

The decoder also keeps the read-mode selector, which chooses between array data, the query table and the identifier codes. It keeps a shortened-program mode in which a program needs only two writes. It also tracks whether an erase is held in suspension. Two status inputs from the engine gate some commands: one says a program is running, the other says an erase is running. A write that breaks a sequence drops the decoder back to idle and starts nothing.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, the read mode is array (code 2'b00), the shortened-program mode is off, no erase is suspended, and all six start pulses are low.
- R2: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 30h@SA raise start_sector_erase, and op_addr is set to SA. Only the low 11 address bits are compared against the key addresses.
- R3: The same five opening writes followed by 10h@555h raise start_chip_erase.
- R4: The writes AAh@555h, 55h@2AAh, A0h@555h, then any address and data, raise start_program. op_addr and op_data take that last write, even when its data is F0h.
- R5: A write that does not match the next expected cycle returns the decoder to idle and starts nothing. The write itself is discarded and does not start a new sequence.
- R6: 98h@55h selects the query-table read mode (2'b01). This works from array mode and from identifier mode, but it is ignored while prog_busy is high.
- R7: AAh@555h, 55h@2AAh, 90h@555h selects the identifier read mode (2'b10). This is ignored while prog_busy is high.
- R8: F0h at any address returns the read mode to array and abandons any partial sequence. The one exception is the data write of a program.
- R9: While the read mode is not array, every write except F0h (and 98h@55h in identifier mode) is ignored, and no start pulse is raised.
- R10: AAh@555h, 55h@2AAh, 20h@555h turn the shortened-program mode on. While it is on, A0h at any address followed by one address/data write raises start_program. 90h then 00h, each at any address, turn it off. Without the mode, a lone A0h starts nothing.
- R11: AAh@555h, 55h@2AAh, 25h@SA raise start_buf_program, and op_addr is set to SA.
- R12: B0h at any address raises start_suspend and sets erase_suspended, but only while erase_busy is high and no erase is already suspended. 30h at any address while suspended raises start_resume and clears erase_suspended.
- R13: While an erase is suspended, erase sequences finish without a pulse. Program and identifier entry are still accepted.
- R14: Each start pulse is high for exactly one cycle, in the cycle after the completing write, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Bus write cycle valid |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the command code is in bits 7:0 |
| prog_busy | input | 1 | Engine is running a program |
| erase_busy | input | 1 | Engine is running an erase |
| start_sector_erase | output | 1 | Start pulse: erase one sector |
| start_chip_erase | output | 1 | Start pulse: erase the whole array |
| start_program | output | 1 | Start pulse: program one word |
| start_buf_program | output | 1 | Start pulse: buffered program |
| start_suspend | output | 1 | Start pulse: suspend the erase |
| start_resume | output | 1 | Start pulse: resume the erase |
| op_addr | output | ADDR_W | Address captured for the last started operation |
| op_data | output | DATA_W | Data captured for the last program |
| rd_mode | output | 2 | Read mode: 00 array, 01 query table, 10 identifier |
| bypass_active | output | 1 | Shortened-program mode is on |
| erase_suspended | output | 1 | An erase is held in suspension |

## Verification
Directed sequences cover each command grammar in full. A second pass breaks each grammar at a chosen cycle, which separates a decoder that truly discards the bad write from one that resynchronises on it. Random non-command writes at random addresses show that stray traffic never starts anything. Random program and sector-erase targets show that op_addr and op_data track the final write, not a key address. The prog_busy, erase_busy, suspended and non-array-mode cases each run the same grammars again, so gating can be told apart from grammar errors.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY   = 2'b00,
      RM_CFI     = 2'b01,
      RM_AUTOSEL = 2'b10
   } rd_mode_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_UNL1,
      SQ_UNL2,
      SQ_ESET,
      SQ_EUNL1,
      SQ_EUNL2,
      SQ_PDATA,
      SQ_BYPX
   } seq_st_e;

   localparam logic [7:0] CMD_UNLK_A    = 8'hAA;
   localparam logic [7:0] CMD_UNLK_B    = 8'h55;
   localparam logic [7:0] CMD_ERASE_SET = 8'h80;
   localparam logic [7:0] CMD_PROG_SET  = 8'hA0;
   localparam logic [7:0] CMD_SECT      = 8'h30;
   localparam logic [7:0] CMD_CHIP      = 8'h10;
   localparam logic [7:0] CMD_CFI       = 8'h98;
   localparam logic [7:0] CMD_AUTOSEL   = 8'h90;
   localparam logic [7:0] CMD_BYP_ON    = 8'h20;
   localparam logic [7:0] CMD_BYP_OFF   = 8'h00;
   localparam logic [7:0] CMD_BUF       = 8'h25;
   localparam logic [7:0] CMD_SUSP      = 8'hB0;
   localparam logic [7:0] CMD_RESUME    = 8'h30;
   localparam logic [7:0] CMD_RESET     = 8'hF0;

   localparam logic [10:0] KEY_555 = 11'h555;
   localparam logic [10:0] KEY_2AA = 11'h2AA;
   localparam logic [10:0] KEY_055 = 11'h055;

   typedef struct packed {
      logic sect;
      logic chip;
      logic prog;
      logic bufp;
      logic susp;
      logic resm;
   } start_t;

   typedef struct packed {
      logic to_cfi;
      logic to_autosel;
      logic to_array;
      logic byp_on;
      logic byp_off;
   } mode_ev_t;

endpackage

// File: rtl/nor_cmd_key_match.sv
module nor_cmd_key_match
   import nor_cmd_pkg::*;
#(
   parameter int KEY_W = 11
) (
   input  logic [KEY_W-1:0] key_addr,
   input  logic             hi_clear,
   output logic             hit_555,
   output logic             hit_2aa,
   output logic             hit_055
);

   localparam logic [KEY_W-1:0] K555 = KEY_W'(KEY_555);
   localparam logic [KEY_W-1:0] K2AA = KEY_W'(KEY_2AA);
   localparam logic [KEY_W-1:0] K055 = KEY_W'(KEY_055);

   always_comb begin
      hit_555 = hi_clear && (key_addr == K555);
      hit_2aa = hi_clear && (key_addr == K2AA);
      hit_055 = hi_clear && (key_addr == K055);
   end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_cmd_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              hit_555,
   input  logic              hit_2aa,
   input  logic              hit_055,
   input  rd_mode_e          rd_mode,
   input  logic              bypass,
   input  logic              susp,
   input  logic              prog_busy,
   input  logic              erase_busy,
   output start_t            start_d,
   output start_t            start_q,
   output mode_ev_t          ev,
   output logic [ADDR_W-1:0] op_addr_q,
   output logic [DATA_W-1:0] op_data_q
);

   seq_st_e    st_q;
   seq_st_e    st_d;
   logic [7:0] cmd;
   logic       load_op;

   assign cmd = wr_data[7:0];

   always_comb begin
      st_d    = st_q;
      start_d = '0;
      ev      = '0;
      if (wr_stb) begin
         st_d = SQ_IDLE;
         if (st_q == SQ_PDATA) begin
            start_d.prog = 1'b1;
         end else if (cmd == CMD_RESET) begin
            ev.to_array = 1'b1;
         end else if (rd_mode != RM_ARRAY) begin
            if (rd_mode == RM_AUTOSEL && cmd == CMD_CFI && hit_055 && !prog_busy)
               ev.to_cfi = 1'b1;
         end else begin
            case (st_q)
               SQ_IDLE: begin
                  if (cmd == CMD_UNLK_A && hit_555)
                     st_d = SQ_UNL1;
                  else if (cmd == CMD_CFI && hit_055 && !prog_busy)
                     ev.to_cfi = 1'b1;
                  else if (cmd == CMD_SUSP && erase_busy && !susp)
                     start_d.susp = 1'b1;
                  else if (cmd == CMD_RESUME && susp)
                     start_d.resm = 1'b1;
                  else if (cmd == CMD_PROG_SET && bypass)
                     st_d = SQ_PDATA;
                  else if (cmd == CMD_AUTOSEL && bypass)
                     st_d = SQ_BYPX;
               end
               SQ_UNL1: begin
                  if (cmd == CMD_UNLK_B && hit_2aa)
                     st_d = SQ_UNL2;
               end
               SQ_UNL2: begin
                  if (cmd == CMD_BUF)
                     start_d.bufp = 1'b1;
                  else if (hit_555) begin
                     if (cmd == CMD_ERASE_SET)
                        st_d = SQ_ESET;
                     else if (cmd == CMD_PROG_SET)
                        st_d = SQ_PDATA;
                     else if (cmd == CMD_AUTOSEL && !prog_busy)
                        ev.to_autosel = 1'b1;
                     else if (cmd == CMD_BYP_ON)
                        ev.byp_on = 1'b1;
                  end
               end
               SQ_ESET: begin
                  if (cmd == CMD_UNLK_A && hit_555)
                     st_d = SQ_EUNL1;
               end
               SQ_EUNL1: begin
                  if (cmd == CMD_UNLK_B && hit_2aa)
                     st_d = SQ_EUNL2;
               end
               SQ_EUNL2: begin
                  if (cmd == CMD_SECT && !susp)
                     start_d.sect = 1'b1;
                  else if (cmd == CMD_CHIP && hit_555 && !susp)
                     start_d.chip = 1'b1;
               end
               SQ_BYPX: begin
                  if (cmd == CMD_BYP_OFF)
                     ev.byp_off = 1'b1;
               end
               default: st_d = SQ_IDLE;
            endcase
         end
      end
   end

   assign load_op = start_d.prog | start_d.sect | start_d.chip | start_d.bufp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         start_q   <= '0;
         op_addr_q <= '0;
         op_data_q <= '0;
      end else begin
         st_q    <= st_d;
         start_q <= start_d;
         if (load_op) begin
            op_addr_q <= wr_addr;
            op_data_q <= wr_data;
         end
      end
   end

endmodule

// File: rtl/nor_cmd_mode_state.sv
module nor_cmd_mode_state
   import nor_cmd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  mode_ev_t ev,
   input  logic     susp_set,
   input  logic     susp_clr,
   output rd_mode_e rd_mode_q,
   output logic     bypass_q,
   output logic     susp_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_mode_q <= RM_ARRAY;
         bypass_q  <= 1'b0;
         susp_q    <= 1'b0;
      end else begin
         if (ev.to_array)
            rd_mode_q <= RM_ARRAY;
         else if (ev.to_cfi)
            rd_mode_q <= RM_CFI;
         else if (ev.to_autosel)
            rd_mode_q <= RM_AUTOSEL;

         if (ev.byp_on)
            bypass_q <= 1'b1;
         else if (ev.byp_off)
            bypass_q <= 1'b0;

         if (susp_set)
            susp_q <= 1'b1;
         else if (susp_clr)
            susp_q <= 1'b0;
      end
   end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
   import nor_cmd_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 16,
   parameter int KEY_W      = 11,
   parameter bit STRICT_KEY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              prog_busy,
   input  logic              erase_busy,
   output logic              start_sector_erase,
   output logic              start_chip_erase,
   output logic              start_program,
   output logic              start_buf_program,
   output logic              start_suspend,
   output logic              start_resume,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic [1:0]        rd_mode,
   output logic              bypass_active,
   output logic              erase_suspended
);

   localparam int HI_W = ADDR_W - KEY_W;

   if (DATA_W < 8) begin : g_bad_data_w
      $error("nor_cmd_decoder: DATA_W must be at least 8");
   end
   if (KEY_W < 11) begin : g_bad_key_w
      $error("nor_cmd_decoder: KEY_W must be at least 11");
   end
   if (HI_W < 1) begin : g_bad_addr_w
      $error("nor_cmd_decoder: ADDR_W must exceed KEY_W");
   end

   logic     hi_clear;
   logic     hit_555;
   logic     hit_2aa;
   logic     hit_055;
   start_t   start_d;
   start_t   start_q;
   mode_ev_t ev;
   rd_mode_e mode_q;
   logic     bypass_q;
   logic     susp_q;

   if (STRICT_KEY) begin : g_strict_key
      assign hi_clear = (wr_addr[ADDR_W-1:KEY_W] == '0);
   end else begin : g_loose_key
      assign hi_clear = 1'b1;
   end

   nor_cmd_key_match #(.KEY_W(KEY_W)) u_match (
      .key_addr (wr_addr[KEY_W-1:0]),
      .hi_clear (hi_clear),
      .hit_555  (hit_555),
      .hit_2aa  (hit_2aa),
      .hit_055  (hit_055)
   );

   nor_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (wr_stb),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .hit_555    (hit_555),
      .hit_2aa    (hit_2aa),
      .hit_055    (hit_055),
      .rd_mode    (mode_q),
      .bypass     (bypass_q),
      .susp       (susp_q),
      .prog_busy  (prog_busy),
      .erase_busy (erase_busy),
      .start_d    (start_d),
      .start_q    (start_q),
      .ev         (ev),
      .op_addr_q  (op_addr),
      .op_data_q  (op_data)
   );

   nor_cmd_mode_state u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .susp_set  (start_d.susp),
      .susp_clr  (start_d.resm),
      .rd_mode_q (mode_q),
      .bypass_q  (bypass_q),
      .susp_q    (susp_q)
   );

   assign start_sector_erase = start_q.sect;
   assign start_chip_erase   = start_q.chip;
   assign start_program      = start_q.prog;
   assign start_buf_program  = start_q.bufp;
   assign start_suspend      = start_q.susp;
   assign start_resume       = start_q.resm;
   assign rd_mode            = mode_q;
   assign bypass_active      = bypass_q;
   assign erase_suspended    = susp_q;

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic [DATA_W-1:0] wr_data,
   input logic              prog_busy,
   input logic              erase_busy,
   input logic              start_sector_erase,
   input logic              start_chip_erase,
   input logic              start_program,
   input logic              start_buf_program,
   input logic              start_suspend,
   input logic              start_resume,
   input logic [1:0]        rd_mode,
   input logic              erase_suspended
);

   logic [5:0] starts;
   assign starts = {start_sector_erase, start_chip_erase, start_program,
                    start_buf_program, start_suspend, start_resume};

   // R1
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mode != 2'b11);

   // R14
   one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(starts));

   // R14
   start_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (starts != 6'b0) |-> $past(wr_stb));

   // R9
   start_in_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (starts != 6'b0) |-> $past(rd_mode) == 2'b00);

   // R13
   no_erase_suspended_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_sector_erase || start_chip_erase) |-> !$past(erase_suspended));

   // R12
   suspend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_suspend |-> ($past(erase_busy) && !$past(erase_suspended) && erase_suspended));

   // R12
   resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_resume |-> ($past(erase_suspended) && !erase_suspended));

   // R6
   cfi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode == 2'b01 && $past(rd_mode) != 2'b01) |->
         ($past(wr_stb) && $past(wr_data[7:0]) == 8'h98));

   // R7
   busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode != $past(rd_mode) && rd_mode != 2'b00) |-> !$past(prog_busy));

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.DATA_W(DATA_W)) u_chk (
   .clk                (clk),
   .rst_n              (rst_n),
   .wr_stb             (wr_stb),
   .wr_data            (wr_data),
   .prog_busy          (prog_busy),
   .erase_busy         (erase_busy),
   .start_sector_erase (start_sector_erase),
   .start_chip_erase   (start_chip_erase),
   .start_program      (start_program),
   .start_buf_program  (start_buf_program),
   .start_suspend      (start_suspend),
   .start_resume       (start_resume),
   .rd_mode            (rd_mode),
   .erase_suspended    (erase_suspended)
);

// File: tb/nor_cmd_decoder_tb.sv
module nor_cmd_decoder_tb;

   localparam int AW = 20;
   localparam int DW = 16;
   localparam logic [5:0] P_NONE = 6'b000000;
   localparam logic [5:0] P_SECT = 6'b100000;
   localparam logic [5:0] P_CHIP = 6'b010000;
   localparam logic [5:0] P_PROG = 6'b001000;
   localparam logic [5:0] P_BUF  = 6'b000100;
   localparam logic [5:0] P_SUSP = 6'b000010;
   localparam logic [5:0] P_RESM = 6'b000001;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          prog_busy = 1'b0;
   logic          erase_busy = 1'b0;
   logic          s_sect, s_chip, s_prog, s_buf, s_susp, s_resm;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;
   logic [1:0]    rd_mode;
   logic          bypass_active;
   logic          erase_suspended;
   logic [5:0]    pulses;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   nor_cmd_decoder u_dut (
      .clk                (clk),
      .rst_n              (rst_n),
      .wr_stb             (wr_stb),
      .wr_addr            (wr_addr),
      .wr_data            (wr_data),
      .prog_busy          (prog_busy),
      .erase_busy         (erase_busy),
      .start_sector_erase (s_sect),
      .start_chip_erase   (s_chip),
      .start_program      (s_prog),
      .start_buf_program  (s_buf),
      .start_suspend      (s_susp),
      .start_resume       (s_resm),
      .op_addr            (op_addr),
      .op_data            (op_data),
      .rd_mode            (rd_mode),
      .bypass_active      (bypass_active),
      .erase_suspended    (erase_suspended)
   );

   assign pulses = {s_sect, s_chip, s_prog, s_buf, s_susp, s_resm};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one bus write; returns at the falling edge after the capturing edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic unlock();
      wr(20'h00555, 16'h00AA);
      wr(20'h002AA, 16'h0055);
   endtask

   task automatic erase_head();
      unlock();
      wr(20'h00555, 16'h0080);
      unlock();
   endtask

   function automatic logic [DW-1:0] junk_data();
      logic [7:0] c;
      do begin
         c = 8'($urandom());
      end while (c == 8'hAA || c == 8'h98 || c == 8'hB0 || c == 8'h30 ||
                 c == 8'hA0 || c == 8'h90 || c == 8'hF0);
      return {8'($urandom()), c};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      void'($urandom(32'h5EED1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pulses", 32'(pulses), 32'(P_NONE));
      chk("R1 rd_mode", 32'(rd_mode), 32'h0);
      chk("R1 bypass", 32'(bypass_active), 32'h0);
      chk("R1 suspended", 32'(erase_suspended), 32'h0);

      // R2 sector erase, R14 single-cycle pulse
      erase_head();
      wr(20'h3A123, 16'h0030);
      chk("R2 sector pulse", 32'(pulses), 32'(P_SECT));
      chk("R2 op_addr", 32'(op_addr), 32'h3A123);
      @(negedge clk);
      chk("R14 pulse drops", 32'(pulses), 32'(P_NONE));

      // R3 chip erase
      erase_head();
      wr(20'h00555, 16'h0010);
      chk("R3 chip pulse", 32'(pulses), 32'(P_CHIP));

      // R4 program, data equal to reset code still programmed
      unlock();
      wr(20'h00555, 16'h00A0);
      wr(20'h12345, 16'h00F0);
      chk("R4 prog pulse", 32'(pulses), 32'(P_PROG));
      chk("R4 op_addr", 32'(op_addr), 32'h12345);
      chk("R4 op_data", 32'(op_data), 32'h00F0);

      // R5 broken erase sequence discarded
      unlock();
      wr(20'h00555, 16'h0080);
      wr(20'h00555, 16'h00AA);
      wr(20'h002AA, 16'h0099);
      wr(20'h01000, 16'h0030);
      chk("R5 broken seq", 32'(pulses), 32'(P_NONE));
      unlock();
      wr(20'h00556, 16'h0080);
      unlock();
      wr(20'h01000, 16'h0030);
      chk("R5 wrong key addr", 32'(pulses), 32'(P_NONE));
      erase_head();
      wr(20'h05000, 16'h0030);
      chk("R5 recovers", 32'(pulses), 32'(P_SECT));

      // R8 reset code abandons partial sequence
      unlock();
      wr(20'h00555, 16'h0080);
      wr(20'h00000, 16'h00F0);
      unlock();
      wr(20'h06000, 16'h0030);
      chk("R8 partial abandoned", 32'(pulses), 32'(P_NONE));

      // R7 identifier mode, R9 commands ignored there
      unlock();
      wr(20'h00555, 16'h0090);
      chk("R7 autosel mode", 32'(rd_mode), 32'h2);
      erase_head();
      wr(20'h07000, 16'h0030);
      chk("R9 no erase in autosel", 32'(pulses), 32'(P_NONE));
      chk("R9 mode kept", 32'(rd_mode), 32'h2);
      wr(20'h00055, 16'h0098);
      chk("R6 cfi from autosel", 32'(rd_mode), 32'h1);
      unlock();
      wr(20'h00555, 16'h00A0);
      wr(20'h00100, 16'h1234);
      chk("R9 no prog in cfi", 32'(pulses), 32'(P_NONE));
      wr(20'h0ABCD, 16'h00F0);
      chk("R8 back to array", 32'(rd_mode), 32'h0);

      // R6 query from array, ignored during program
      wr(20'h00055, 16'h0098);
      chk("R6 cfi from array", 32'(rd_mode), 32'h1);
      wr(20'h00000, 16'h00F0);
      prog_busy = 1'b1;
      wr(20'h00055, 16'h0098);
      chk("R6 cfi ignored busy", 32'(rd_mode), 32'h0);
      unlock();
      wr(20'h00555, 16'h0090);
      chk("R7 autosel ignored busy", 32'(rd_mode), 32'h0);
      prog_busy = 1'b0;

      // R10 shortened program
      wr(20'h00555, 16'h00A0);
      wr(20'h00200, 16'h4321);
      chk("R10 lone A0 ignored", 32'(pulses), 32'(P_NONE));
      unlock();
      wr(20'h00555, 16'h0020);
      chk("R10 bypass on", 32'(bypass_active), 32'h1);
      wr(20'h0F00F, 16'h00A0);
      wr(20'h22222, 16'hBEEF);
      chk("R10 bypass prog", 32'(pulses), 32'(P_PROG));
      chk("R10 bypass op_data", 32'(op_data), 32'hBEEF);
      wr(20'h00001, 16'h0090);
      wr(20'h00002, 16'h0000);
      chk("R10 bypass off", 32'(bypass_active), 32'h0);

      // R11 buffered program
      unlock();
      wr(20'h44000, 16'h0025);
      chk("R11 buf pulse", 32'(pulses), 32'(P_BUF));
      chk("R11 op_addr", 32'(op_addr), 32'h44000);

      // R12 suspend gating and resume, R13 behaviour while suspended
      wr(20'h00000, 16'h00B0);
      chk("R12 suspend needs busy", 32'(pulses), 32'(P_NONE));
      erase_busy = 1'b1;
      wr(20'h00000, 16'h00B0);
      chk("R12 suspend pulse", 32'(pulses), 32'(P_SUSP));
      chk("R12 suspended flag", 32'(erase_suspended), 32'h1);
      erase_head();
      wr(20'h08000, 16'h0030);
      chk("R13 erase blocked", 32'(pulses), 32'(P_NONE));
      unlock();
      wr(20'h00555, 16'h00A0);
      wr(20'h09000, 16'h5555);
      chk("R13 prog allowed", 32'(pulses), 32'(P_PROG));
      unlock();
      wr(20'h00555, 16'h0090);
      chk("R13 autosel allowed", 32'(rd_mode), 32'h2);
      wr(20'h00000, 16'h00F0);
      wr(20'h00000, 16'h0030);
      chk("R12 resume pulse", 32'(pulses), 32'(P_RESM));
      chk("R12 resume clears", 32'(erase_suspended), 32'h0);
      erase_busy = 1'b0;

      // R5 random non-command traffic
      for (int i = 0; i < 200; i++) begin
         wr(AW'($urandom()), junk_data());
         chk("R5 random junk", 32'({pulses, rd_mode}), 32'({P_NONE, 2'b00}));
      end

      // R4 random program targets
      for (int i = 0; i < 100; i++) begin
         a = AW'($urandom());
         d = DW'($urandom());
         unlock();
         wr(20'h00555, 16'h00A0);
         wr(a, d);
         chk("R4 random prog", 32'(pulses), 32'(P_PROG));
         chk("R4 random addr", 32'(op_addr), 32'(a));
         chk("R4 random data", 32'(op_data), 32'(d));
      end

      // R2 random sector targets
      for (int i = 0; i < 60; i++) begin
         a = AW'($urandom());
         erase_head();
         wr(a, 16'h0030);
         chk("R2 random sect", 32'(pulses), 32'(P_SECT));
         chk("R2 random addr", 32'(op_addr), 32'(a));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule